// File: doc/BRIEF.md
# Receive Byte Queue with Flush on Disable and Abort Acknowledge

This block holds the bytes that a serial bus controller's protocol engine has received until software drains them through the register interface. The engine writes one byte per push strobe. A register read pops the oldest byte, which appears on the read data output one clock later. The block keeps a live count of stored bytes at all times. It presents that count both as a narrow field and as a full 32-bit register word whose unused upper bits read zero. Full and empty flags, plus sticky overflow and underflow flags, report misuse.

The queue empties itself in two situations. The first is when the controller enable is low. The second is when software reads the abort-clear register while a transmit abort is pending. Either condition, sampled at a clock edge, returns the count to zero, discards all stored bytes and clears the sticky flags. A flush outranks any push or pop presented in the same cycle.

Top module: `rxq_flush_fifo`

## Requirements
- R1: An accepted push raises `level_o` by one and an accepted pop lowers it by one, visible on the clock edge that takes the strobe.
- R2: `level_word_o` carries the count in bits 4:0, and bits 31:5 are always zero.
- R3: After synchronous reset, the outputs are level 0, `empty_o` 1, `full_o` 0, both sticky flags 0 and `rd_data_o` 0.
- R4: A clock edge with `ctrl_en_i` low leaves level 0 and `empty_o` 1, and no earlier byte can be popped afterwards.
- R5: A clock edge with `abort_clr_rd_i` and `abort_pend_i` both high flushes the queue in the same way; `abort_clr_rd_i` without `abort_pend_i` changes nothing.
- R6: The queue holds 16 bytes. `full_o` is 1 exactly at level 16 and `empty_o` is 1 exactly at level 0.
- R7: A push and a pop in the same cycle leave the level unchanged and are both accepted, including when full.
- R8: A push while full without a pop is dropped and sets `overflow_o`, which stays set until reset or a flush.
- R9: A pop while empty drives `rd_data_o` to 0 on the next cycle and sets `underflow_o`, which stays set until reset or a flush.
- R10: A flush outranks any push or pop in the same cycle: neither is performed, no sticky flag is set, and `rd_data_o` keeps its value.
- R11: Pops return bytes in push order, each on `rd_data_o` the cycle after its pop strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push strobe from the bus engine |
| push_data_i | input | 8 | Byte to store |
| pop_i | input | 1 | Pop strobe from the register interface |
| ctrl_en_i | input | 1 | Controller enable; low flushes |
| abort_pend_i | input | 1 | Transmit abort pending |
| abort_clr_rd_i | input | 1 | Read strobe of the abort-clear register |
| rd_data_o | output | 8 | Popped byte, registered |
| level_o | output | 5 | Stored byte count 0..16 |
| level_word_o | output | 32 | Count as a 32-bit register word |
| full_o | output | 1 | Count equals depth |
| empty_o | output | 1 | Count equals zero |
| overflow_o | output | 1 | Sticky: push dropped while full |
| underflow_o | output | 1 | Sticky: pop while empty |

## Verification
The hardest case to reach is a full queue receiving a push and a pop in the same cycle. In that cycle the write address equals the read address, so the popped byte must be the old contents and not the new byte. The stimulus first fills all sixteen slots with a known pattern, then issues the simultaneous strobes and drains the queue while checking the order. A second hard case is a flush that coincides with push and pop strobes. Directed cycles line these up with a disable and with an abort acknowledgement, and a long random phase then mixes all strobes while every output is compared with a queue-based model on each clock.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic flush;
    logic push_ok;
    logic push_drop;
    logic pop_ok;
    logic pop_under;
  } rxq_cmd_t;

endpackage

// File: rtl/rxq_arbiter.sv
module rxq_arbiter
  import rxq_pkg::*;
(
  input  logic     push_i,
  input  logic     pop_i,
  input  logic     ctrl_en_i,
  input  logic     abort_pend_i,
  input  logic     abort_clr_rd_i,
  input  logic     full_i,
  input  logic     empty_i,
  output rxq_cmd_t cmd_o
);

  logic flush;
  logic pop_ok;

  assign flush  = ~ctrl_en_i | (abort_pend_i & abort_clr_rd_i);
  assign pop_ok = pop_i & ~empty_i & ~flush;

  always_comb begin
    cmd_o           = '0;
    cmd_o.flush     = flush;
    cmd_o.pop_ok    = pop_ok;
    cmd_o.pop_under = pop_i & empty_i & ~flush;
    cmd_o.push_ok   = push_i & ~flush & (~full_i | pop_ok);
    cmd_o.push_drop = push_i & ~flush & full_i & ~pop_ok;
  end

endmodule

// File: rtl/rxq_mem.sv
module rxq_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] store_r [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) store_r[waddr_i] <= wdata_i;
  end

  // read-first: a same-address write in this cycle is not seen
  always_ff @(posedge clk) begin
    if (re_i) rdata_q <= store_r[raddr_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  rxq_cmd_t          cmd_i,
  output logic [ADDR_W-1:0] wr_ptr_o,
  output logic [ADDR_W-1:0] rd_ptr_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              overflow_o,
  output logic              underflow_o,
  output logic              rd_zero_o
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0]  FULL = LVL_W'(DEPTH);

  logic [ADDR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0]  level_q, level_nx;
  logic              full_q, empty_q, ovf_q, udf_q, zero_q;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    level_nx = level_q;
    case ({cmd_i.push_ok, cmd_i.pop_ok})
      2'b10:   level_nx = level_q + 1'b1;
      2'b01:   level_nx = level_q - 1'b1;
      default: level_nx = level_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      full_q   <= 1'b0;
      empty_q  <= 1'b1;
      ovf_q    <= 1'b0;
      udf_q    <= 1'b0;
      zero_q   <= 1'b1;
    end else if (cmd_i.flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      full_q   <= 1'b0;
      empty_q  <= 1'b1;
      ovf_q    <= 1'b0;
      udf_q    <= 1'b0;
    end else begin
      if (cmd_i.push_ok)   wr_ptr_q <= bump(wr_ptr_q);
      if (cmd_i.pop_ok)    rd_ptr_q <= bump(rd_ptr_q);
      if (cmd_i.push_drop) ovf_q    <= 1'b1;
      if (cmd_i.pop_under) udf_q    <= 1'b1;
      if (cmd_i.pop_under) zero_q   <= 1'b1;
      else if (cmd_i.pop_ok) zero_q <= 1'b0;
      level_q <= level_nx;
      full_q  <= (level_nx == FULL);
      empty_q <= (level_nx == '0);
    end
  end

  assign wr_ptr_o    = wr_ptr_q;
  assign rd_ptr_o    = rd_ptr_q;
  assign level_o     = level_q;
  assign full_o      = full_q;
  assign empty_o     = empty_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = udf_q;
  assign rd_zero_o   = zero_q;

endmodule

// File: rtl/rxq_flush_fifo.sv
module rxq_flush_fifo
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push_i,
  input  logic [DATA_W-1:0]            push_data_i,
  input  logic                         pop_i,
  input  logic                         ctrl_en_i,
  input  logic                         abort_pend_i,
  input  logic                         abort_clr_rd_i,
  output logic [DATA_W-1:0]            rd_data_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o,
  output logic [WORD_W-1:0]            level_word_o,
  output logic                         full_o,
  output logic                         empty_o,
  output logic                         overflow_o,
  output logic                         underflow_o
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int LVL_W  = $clog2(DEPTH + 1);

  rxq_cmd_t          cmd;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [DATA_W-1:0] mem_q;
  logic              rd_zero;

  rxq_arbiter u_arb (
    .push_i         (push_i),
    .pop_i          (pop_i),
    .ctrl_en_i      (ctrl_en_i),
    .abort_pend_i   (abort_pend_i),
    .abort_clr_rd_i (abort_clr_rd_i),
    .full_i         (full_o),
    .empty_i        (empty_o),
    .cmd_o          (cmd)
  );

  rxq_ptr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cmd_i       (cmd),
    .wr_ptr_o    (wr_ptr),
    .rd_ptr_o    (rd_ptr),
    .level_o     (level_o),
    .full_o      (full_o),
    .empty_o     (empty_o),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o),
    .rd_zero_o   (rd_zero)
  );

  rxq_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .we_i    (cmd.push_ok),
    .waddr_i (wr_ptr),
    .wdata_i (push_data_i),
    .re_i    (cmd.pop_ok),
    .raddr_i (rd_ptr),
    .rdata_o (mem_q)
  );

  assign rd_data_o = rd_zero ? '0 : mem_q;

  generate
    if (WORD_W > LVL_W) begin : g_pad
      assign level_word_o = {{(WORD_W-LVL_W){1'b0}}, level_o};
    end else begin : g_trunc
      assign level_word_o = level_o[WORD_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/rxq_flush_fifo_chk.sv
module rxq_flush_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             push_i,
  input logic             pop_i,
  input logic             ctrl_en_i,
  input logic             abort_pend_i,
  input logic             abort_clr_rd_i,
  input logic [LVL_W-1:0] level_o,
  input logic             full_o,
  input logic             empty_o,
  input logic             overflow_o
);

  logic flush_in;
  assign flush_in = !ctrl_en_i || (abort_pend_i && abort_clr_rd_i);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level_o <= LVL_W'(DEPTH)); // R6

  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(full_o && empty_o)); // R6

  AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en_i |=> (level_o == '0) && empty_o); // R4

  AST_ABORT_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (abort_pend_i && abort_clr_rd_i) |=> (level_o == '0) && !overflow_o); // R5

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    (!flush_in && push_i && !pop_i && !full_o) |=>
      level_o == LVL_W'($past(level_o) + 1'b1)); // R1

  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!flush_in && push_i && pop_i && !empty_o) |=> $stable(level_o)); // R7

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overflow_o && !flush_in) |=> overflow_o); // R8

endmodule

bind rxq_flush_fifo rxq_flush_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .push_i         (push_i),
  .pop_i          (pop_i),
  .ctrl_en_i      (ctrl_en_i),
  .abort_pend_i   (abort_pend_i),
  .abort_clr_rd_i (abort_clr_rd_i),
  .level_o        (level_o),
  .full_o         (full_o),
  .empty_o        (empty_o),
  .overflow_o     (overflow_o)
);

// File: tb/rxq_flush_fifo_tb_top.sv
`timescale 1ns/1ps
module rxq_flush_fifo_tb_top;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       push_i = 1'b0;
  logic [7:0] push_data_i = 8'h00;
  logic       pop_i = 1'b0;
  logic       ctrl_en_i = 1'b1;
  logic       abort_pend_i = 1'b0;
  logic       abort_clr_rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [4:0] level_o;
  logic [31:0] level_word_o;
  logic       full_o, empty_o, overflow_o, underflow_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] mq[$];
  logic [7:0] m_rd = 8'h00;
  bit         m_ovf = 0;
  bit         m_udf = 0;

  always #5 clk = ~clk;

  rxq_flush_fifo dut_i (
    .clk (clk), .rst (rst),
    .push_i (push_i), .push_data_i (push_data_i), .pop_i (pop_i),
    .ctrl_en_i (ctrl_en_i), .abort_pend_i (abort_pend_i),
    .abort_clr_rd_i (abort_clr_rd_i),
    .rd_data_o (rd_data_o), .level_o (level_o), .level_word_o (level_word_o),
    .full_o (full_o), .empty_o (empty_o),
    .overflow_o (overflow_o), .underflow_o (underflow_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int lv = mq.size();
    chk(level_o == 5'(lv), "R1 level", level_o, lv);
    chk(level_word_o == 32'(lv), "R2 level word", level_word_o, lv);
    chk(full_o == (lv == DEPTH), "R6 full", full_o, lv == DEPTH);
    chk(empty_o == (lv == 0), "R6 empty", empty_o, lv == 0);
    chk(overflow_o == m_ovf, "R8 overflow", overflow_o, m_ovf);
    chk(underflow_o == m_udf, "R9 underflow", underflow_o, m_udf);
    chk(rd_data_o == m_rd, "R11 read data", rd_data_o, m_rd);
  endtask

  task automatic model_step();
    bit flush = !ctrl_en_i || (abort_pend_i && abort_clr_rd_i);
    bit pop_ok, push_ok;
    if (flush) begin
      mq.delete();
      m_ovf = 0;
      m_udf = 0;
    end else begin
      pop_ok  = pop_i && (mq.size() > 0);
      push_ok = push_i && ((mq.size() < DEPTH) || pop_ok);
      if (pop_i) begin
        if (pop_ok) m_rd = mq.pop_front();
        else begin m_rd = 8'h00; m_udf = 1; end
      end
      if (push_ok) mq.push_back(push_data_i);
      else if (push_i) m_ovf = 1;
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(input bit p, input logic [7:0] d, input bit pp,
                     input bit en, input bit ap, input bit cr);
    push_i = p; push_data_i = d; pop_i = pp;
    ctrl_en_i = en; abort_pend_i = ap; abort_clr_rd_i = cr;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R3 reset state
    chk(level_o == 0 && empty_o && !full_o, "R3 reset level/flags", level_o, 0);
    chk(!overflow_o && !underflow_o && rd_data_o == 0, "R3 reset sticky/data", rd_data_o, 0);
    compare_all();

    // R6 fill to 16, R1 counting
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'hA0 + 8'(i), 0, 1, 0, 0);
    chk(full_o && level_o == 16, "R6 full at sixteen", level_o, 16);
    // R8 push while full dropped
    cyc(1, 8'hEE, 0, 1, 0, 0);
    chk(overflow_o && level_o == 16, "R8 overflow on full push", overflow_o, 1);
    // R7 push and pop while full
    cyc(1, 8'h55, 1, 1, 0, 0);
    chk(level_o == 16 && rd_data_o == 8'hA0, "R7 full push+pop", rd_data_o, 8'hA0);
    // R11 drain in order
    for (int i = 1; i < DEPTH; i++) begin
      cyc(0, 0, 1, 1, 0, 0);
      chk(rd_data_o == 8'hA0 + 8'(i), "R11 order", rd_data_o, 8'hA0 + i);
    end
    cyc(0, 0, 1, 1, 0, 0);
    chk(rd_data_o == 8'h55, "R11 last byte", rd_data_o, 8'h55);
    // R9 pop empty
    cyc(0, 0, 1, 1, 0, 0);
    chk(rd_data_o == 0 && underflow_o, "R9 pop while empty", rd_data_o, 0);
    // R4 disable flush
    for (int i = 0; i < 5; i++) cyc(1, 8'h10 + 8'(i), 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk(level_o == 0 && empty_o && !overflow_o, "R4 disable flush", level_o, 0);
    cyc(0, 0, 1, 1, 0, 0);
    chk(rd_data_o == 0 && underflow_o, "R4 contents gone", rd_data_o, 0);
    // R5 clear read without pending: no effect
    for (int i = 0; i < 3; i++) cyc(1, 8'h30 + 8'(i), 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 1);
    chk(level_o == 3, "R5 clear read without pending", level_o, 3);
    cyc(0, 0, 0, 1, 1, 0);
    chk(level_o == 3, "R5 pending alone", level_o, 3);
    cyc(0, 0, 0, 1, 1, 1);
    chk(level_o == 0 && empty_o, "R5 abort acknowledge flush", level_o, 0);
    // R10 flush beats push and pop
    for (int i = 0; i < 2; i++) cyc(1, 8'h40 + 8'(i), 0, 1, 0, 0);
    cyc(0, 0, 1, 1, 0, 0);
    cyc(1, 8'h77, 1, 0, 0, 0);
    chk(level_o == 0 && rd_data_o == 8'h40, "R10 disable beats push/pop", rd_data_o, 8'h40);
    cyc(1, 8'h78, 1, 1, 1, 1);
    chk(level_o == 0 && !underflow_o && !overflow_o, "R10 abort flush beats strobes", level_o, 0);
    // R7 push+pop while empty: pop underflows, push lands
    cyc(1, 8'h99, 1, 1, 0, 0);
    chk(level_o == 1 && underflow_o, "R7 push+pop at empty", level_o, 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      cyc($urandom_range(0, 99) < 55, 8'($urandom), $urandom_range(0, 99) < 45,
          r >= 2, $urandom_range(0, 9) < 3, r >= 2 && r < 5);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule